// File: doc/BRIEF.md
# Microcode Patch Download Controller

The controller copies a fixed-size microcode patch image from system memory into an on-chip patch store. Software starts it by writing the image's base address into a trigger register. From then on the block runs by itself. It fetches the 2048-byte image one byte at a time through a request/response read port, keeps the first twelve header bytes (a date stamp, the processor identifier the image was built for, and an integrity checksum), and discards the rest of the 48-byte header. It then writes the 2000 payload bytes into the patch store in ascending order.

When the header's processor identifier has been received in full, the controller compares it with a fixed local identifier. If the two differ, the download is abandoned before any payload byte is fetched. The checksum is kept only so that other logic can read it. It never influences the transfer. When a download completes, the block emits a completion pulse and then a one-cycle strobe that launches the initialization routine at the head of the payload. That routine may program the patch match registers.

Both streaming interfaces use valid/ready. A request or a store write is offered with its valid signal and is held unchanged until the matching ready is seen high at a clock edge. Either sink may hold ready low for any number of cycles. Only one read is outstanding at a time. The controller asserts `rd_rsp_ready` only while it is waiting for the response to an accepted request, and the memory side must present exactly one response per accepted request.

Top module: `ucode_patch_loader`

## Requirements
- R1: After reset, `busy`, `done`, `init_start`, `id_err`, `rd_req_valid`, `rd_rsp_ready` and `ps_valid` are all low.
- R2: A `trig_we` pulse while idle latches `trig_addr` as the base and makes `busy` high from the next cycle. The block then reads the addresses base+0 through base+2047, each exactly once, in ascending order.
- R3: `rd_req_valid` stays high with `rd_req_addr` unchanged until `rd_req_ready` is sampled high. No new request is made before the response to the previous one arrives. `rd_rsp_ready` is high while a response is awaited and low while a request is offered.
- R4: Header bytes are captured least significant byte first. Offsets 0–3 form `hdr_date`, offsets 4–7 form `hdr_cpu_id`, and offsets 8–11 form `hdr_csum`. Offsets 12–47 are discarded.
- R5: The image byte at offset 48+k is written to patch store address k, for k = 0..1999, once each and in ascending order. `ps_valid` holds with `ps_addr` and `ps_data` stable until `ps_ready`.
- R6: The value of the checksum field has no effect on the transfer or on completion.
- R7: If the assembled identifier differs from `local_id` once offset 7 has arrived, the block reads nothing further and writes nothing to the patch store. `id_err` rises, neither `done` nor `init_start` pulses, and the block returns to idle.
- R8: `id_err` stays high while idle and is cleared by the next accepted trigger.
- R9: After the final store write is accepted, `done` is high for one cycle and `init_start` is high for exactly the following cycle. `busy` is still high in the `init_start` cycle and low in the cycle after.
- R10: A `trig_we` pulse while `busy` is high is ignored. The running download continues from its original base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| trig_we | input | 1 | Trigger register write strobe |
| trig_addr | input | ADDR_W | Image base address written with the trigger |
| local_id | input | 32 | Identifier of this processor |
| rd_req_valid | output | 1 | Read request offered |
| rd_req_ready | input | 1 | Read request accepted |
| rd_req_addr | output | ADDR_W | Byte address of the read request |
| rd_rsp_valid | input | 1 | Read response valid |
| rd_rsp_ready | output | 1 | Controller waiting for a read response |
| rd_rsp_data | input | 8 | Read response byte |
| ps_valid | output | 1 | Patch store write offered |
| ps_ready | input | 1 | Patch store write accepted |
| ps_addr | output | PS_AW | Patch store byte address |
| ps_data | output | 8 | Patch store byte |
| busy | output | 1 | Download in progress |
| done | output | 1 | One-cycle completion pulse |
| init_start | output | 1 | One-cycle strobe launching the initialization routine |
| id_err | output | 1 | Identifier mismatch, held until the next accepted trigger |
| hdr_date | output | 32 | Captured date field |
| hdr_cpu_id | output | 32 | Captured target identifier |
| hdr_csum | output | 32 | Captured checksum (not evaluated) |

## Verification
The embedded properties assume that the memory side drives `rd_rsp_valid` only after it has accepted a request, for a single cycle, and only once per request. The bench responder follows this rule. It offers a response only from its own record of an accepted request and withdraws it on the next cycle. Stall counts on request acceptance, response latency and store acceptance are varied between runs, so the hold properties are exercised under back-pressure. The trigger and local identifier are driven only at falling edges and are held constant during a run.

// File: rtl/upl_pkg.sv
package upl_pkg;
  localparam int FLD_DATE = 0;
  localparam int FLD_ID   = 4;
  localparam int FLD_CSUM = 8;
  localparam int FLD_END  = 12;

  typedef enum logic [2:0] {
    ST_IDLE, ST_REQ, ST_RSP, ST_WR, ST_DONE, ST_INIT
  } upl_state_e;
endpackage

// File: rtl/upl_fetch.sv
module upl_fetch #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] base_in,
  input  logic              step,
  output logic [IDX_W-1:0]  idx,
  output logic [ADDR_W-1:0] rd_addr
);
  logic [ADDR_W-1:0] base_q;
  logic [IDX_W-1:0]  idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      idx_q  <= '0;
    end else if (load) begin
      base_q <= base_in;
      idx_q  <= '0;
    end else if (step) begin
      idx_q <= idx_q + 1'b1;
    end
  end

  assign idx     = idx_q;
  assign rd_addr = base_q + ADDR_W'(idx_q);
endmodule

// File: rtl/upl_hdr_cap.sv
module upl_hdr_cap import upl_pkg::*; #(
  parameter int IDX_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             bvld,
  input  logic [IDX_W-1:0] idx,
  input  logic [7:0]       bdata,
  input  logic [31:0]      local_id,
  output logic [31:0]      date,
  output logic [31:0]      cpu_id,
  output logic [31:0]      csum,
  output logic             id_bad
);
  logic [7:0] hb [FLD_END];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < FLD_END; i++) hb[i] <= '0;
    end else if (clr) begin
      for (int i = 0; i < FLD_END; i++) hb[i] <= '0;
    end else if (bvld) begin
      for (int i = 0; i < FLD_END; i++)
        if (idx == IDX_W'(i)) hb[i] <= bdata;
    end
  end

  assign date   = {hb[FLD_DATE+3], hb[FLD_DATE+2], hb[FLD_DATE+1], hb[FLD_DATE]};
  assign cpu_id = {hb[FLD_ID+3],   hb[FLD_ID+2],   hb[FLD_ID+1],   hb[FLD_ID]};
  assign csum   = {hb[FLD_CSUM+3], hb[FLD_CSUM+2], hb[FLD_CSUM+1], hb[FLD_CSUM]};

  // Mismatch seen as the top identifier byte arrives; the sequencer gates it.
  assign id_bad = (idx == IDX_W'(FLD_ID + 3)) &&
                  ({bdata, hb[FLD_ID+2], hb[FLD_ID+1], hb[FLD_ID]} != local_id);
endmodule

// File: rtl/upl_store_wr.sv
module upl_store_wr #(
  parameter int IDX_W     = 11,
  parameter int PS_AW     = 11,
  parameter int HDR_BYTES = 48
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap,
  input  logic [IDX_W-1:0] idx,
  input  logic [7:0]       bdata,
  output logic [PS_AW-1:0] ps_addr,
  output logic [7:0]       ps_data
);
  logic [IDX_W-1:0] rel;
  assign rel = idx - IDX_W'(HDR_BYTES);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ps_addr <= '0;
      ps_data <= '0;
    end else if (cap) begin
      ps_addr <= PS_AW'(rel);
      ps_data <= bdata;
    end
  end
endmodule

// File: rtl/upl_seq.sv
module upl_seq import upl_pkg::*; #(
  parameter int IDX_W     = 11,
  parameter int IMG_BYTES = 2048,
  parameter int HDR_BYTES = 48
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig_we,
  input  logic [IDX_W-1:0] idx,
  input  logic             id_bad,
  input  logic             rd_req_ready,
  input  logic             rd_rsp_valid,
  input  logic             ps_ready,
  output logic             load,
  output logic             step,
  output logic             cap,
  output logic             hdr_vld,
  output logic             rd_req_valid,
  output logic             rd_rsp_ready,
  output logic             ps_valid,
  output logic             busy,
  output logic             done,
  output logic             init_start,
  output logic             id_err
);
  upl_state_e st, nxt;
  logic in_pay, last, err_set, err_q;

  assign in_pay  = idx >= IDX_W'(HDR_BYTES);
  assign last    = idx == IDX_W'(IMG_BYTES - 1);
  assign hdr_vld = (st == ST_RSP) && rd_rsp_valid && !in_pay;

  always_comb begin
    nxt     = st;
    load    = 1'b0;
    step    = 1'b0;
    cap     = 1'b0;
    err_set = 1'b0;
    unique case (st)
      ST_IDLE: if (trig_we) begin load = 1'b1; nxt = ST_REQ; end
      ST_REQ:  if (rd_req_ready) nxt = ST_RSP;
      ST_RSP:
        if (rd_rsp_valid) begin
          if (in_pay) begin
            cap = 1'b1;
            nxt = ST_WR;
          end else if (id_bad) begin
            err_set = 1'b1;
            nxt     = ST_IDLE;
          end else begin
            step = 1'b1;
            nxt  = ST_REQ;
          end
        end
      ST_WR:
        if (ps_ready) begin
          if (last) nxt = ST_DONE;
          else begin step = 1'b1; nxt = ST_REQ; end
        end
      ST_DONE: nxt = ST_INIT;
      ST_INIT: nxt = ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= ST_IDLE;
      err_q <= 1'b0;
    end else begin
      st <= nxt;
      if (load)         err_q <= 1'b0;
      else if (err_set) err_q <= 1'b1;
    end
  end

  assign rd_req_valid = (st == ST_REQ);
  assign rd_rsp_ready = (st == ST_RSP);
  assign ps_valid     = (st == ST_WR);
  assign busy         = (st != ST_IDLE);
  assign done         = (st == ST_DONE);
  assign init_start   = (st == ST_INIT);
  assign id_err       = err_q;

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid && !rd_req_ready |=> rd_req_valid); // R3
  AST_ERR_STAYS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    id_err && !trig_we |=> id_err); // R8
endmodule

// File: rtl/ucode_patch_loader.sv
module ucode_patch_loader import upl_pkg::*; #(
  parameter int ADDR_W    = 32,
  parameter int IMG_BYTES = 2048,
  parameter int HDR_BYTES = 48,
  localparam int PAY_BYTES = IMG_BYTES - HDR_BYTES,
  localparam int IDX_W     = $clog2(IMG_BYTES),
  localparam int PS_AW     = $clog2(PAY_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trig_we,
  input  logic [ADDR_W-1:0] trig_addr,
  input  logic [31:0]       local_id,
  output logic              rd_req_valid,
  input  logic              rd_req_ready,
  output logic [ADDR_W-1:0] rd_req_addr,
  input  logic              rd_rsp_valid,
  output logic              rd_rsp_ready,
  input  logic [7:0]        rd_rsp_data,
  output logic              ps_valid,
  input  logic              ps_ready,
  output logic [PS_AW-1:0]  ps_addr,
  output logic [7:0]        ps_data,
  output logic              busy,
  output logic              done,
  output logic              init_start,
  output logic              id_err,
  output logic [31:0]       hdr_date,
  output logic [31:0]       hdr_cpu_id,
  output logic [31:0]       hdr_csum
);
  logic             load, step, cap, hdr_vld, id_bad;
  logic [IDX_W-1:0] idx;

  upl_fetch #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_fetch (
    .clk(clk), .rst_n(rst_n), .load(load), .base_in(trig_addr),
    .step(step), .idx(idx), .rd_addr(rd_req_addr)
  );

  upl_hdr_cap #(.IDX_W(IDX_W)) u_hdr (
    .clk(clk), .rst_n(rst_n), .clr(load), .bvld(hdr_vld), .idx(idx),
    .bdata(rd_rsp_data), .local_id(local_id), .date(hdr_date),
    .cpu_id(hdr_cpu_id), .csum(hdr_csum), .id_bad(id_bad)
  );

  upl_store_wr #(.IDX_W(IDX_W), .PS_AW(PS_AW), .HDR_BYTES(HDR_BYTES)) u_wr (
    .clk(clk), .rst_n(rst_n), .cap(cap), .idx(idx), .bdata(rd_rsp_data),
    .ps_addr(ps_addr), .ps_data(ps_data)
  );

  upl_seq #(.IDX_W(IDX_W), .IMG_BYTES(IMG_BYTES), .HDR_BYTES(HDR_BYTES)) u_seq (
    .clk(clk), .rst_n(rst_n), .trig_we(trig_we), .idx(idx), .id_bad(id_bad),
    .rd_req_ready(rd_req_ready), .rd_rsp_valid(rd_rsp_valid), .ps_ready(ps_ready),
    .load(load), .step(step), .cap(cap), .hdr_vld(hdr_vld),
    .rd_req_valid(rd_req_valid), .rd_rsp_ready(rd_rsp_ready), .ps_valid(ps_valid),
    .busy(busy), .done(done), .init_start(init_start), .id_err(id_err)
  );

  AST_REQ_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid && !rd_req_ready |=> $stable(rd_req_addr)); // R3
  AST_PS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ps_valid && !ps_ready |=> ps_valid && $stable(ps_addr) && $stable(ps_data)); // R5
  AST_PS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    ps_valid |-> ps_addr < PS_AW'(PAY_BYTES)); // R5
  AST_INIT_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> init_start && busy); // R9
  AST_NO_WRITE_ON_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    id_err |-> !ps_valid && !done); // R7
endmodule

// File: tb/ucode_patch_loader_test.sv
module ucode_patch_loader_test;
  localparam int IMG = 2048;
  localparam int HDR = 48;
  localparam int PAY = IMG - HDR;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        trig_we = 1'b0;
  logic [31:0] trig_addr = '0;
  logic [31:0] local_id = '0;
  logic        rd_req_valid, rd_rsp_ready, ps_valid;
  logic        rd_req_ready = 1'b0;
  logic        rd_rsp_valid = 1'b0;
  logic [7:0]  rd_rsp_data = '0;
  logic        ps_ready = 1'b0;
  logic [31:0] rd_req_addr;
  logic [10:0] ps_addr;
  logic [7:0]  ps_data;
  logic        busy, done, init_start, id_err;
  logic [31:0] hdr_date, hdr_cpu_id, hdr_csum;

  always #10 clk = ~clk;

  ucode_patch_loader uut (
    .clk(clk), .rst_n(rst_n), .trig_we(trig_we), .trig_addr(trig_addr),
    .local_id(local_id), .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready),
    .rd_req_addr(rd_req_addr), .rd_rsp_valid(rd_rsp_valid), .rd_rsp_ready(rd_rsp_ready),
    .rd_rsp_data(rd_rsp_data), .ps_valid(ps_valid), .ps_ready(ps_ready),
    .ps_addr(ps_addr), .ps_data(ps_data), .busy(busy), .done(done),
    .init_start(init_start), .id_err(id_err), .hdr_date(hdr_date),
    .hdr_cpu_id(hdr_cpu_id), .hdr_csum(hdr_csum)
  );

  int n_chk = 0, n_fail = 0;
  logic [31:0] img_base, img_date, img_id, img_csum;
  int req_stall_cfg, lat_cfg, ps_stall_cfg;
  int rd_count, rd_bad, wr_count, wr_bad, proto_bad;
  int done_count, init_count, init_bad, busy_bad;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pay_byte(input int k);
    return 8'((k * 29 + (k >> 5) + int'(img_base[7:0])) & 255);
  endfunction

  function automatic logic [7:0] img_byte(input int off);
    if (off < 0 || off >= IMG) return 8'h00;
    if (off < 4)   return img_date[8*off +: 8];
    if (off < 8)   return img_id[8*(off-4) +: 8];
    if (off < 12)  return img_csum[8*(off-8) +: 8];
    if (off < HDR) return 8'h5A ^ 8'(off);
    return pay_byte(off - HDR);
  endfunction

  // Memory responder and patch-store sink, acting on falling edges.
  initial begin
    bit pend = 0;
    int pend_off = 0, lat_left = 0, rq_left = 0, ps_left = 0;
    forever begin
      @(negedge clk);
      if (rd_rsp_valid) rd_rsp_valid = 1'b0;
      if (pend) begin
        if (lat_left == 0) begin
          if (!rd_rsp_ready) proto_bad++;
          rd_rsp_valid = 1'b1;
          rd_rsp_data  = img_byte(pend_off);
          pend = 0;
        end else lat_left--;
      end
      rd_req_ready = 1'b0;
      if (rd_req_valid) begin
        if (rd_rsp_ready || pend) proto_bad++;
        if (rd_req_addr != img_base + 32'(rd_count)) rd_bad++;
        if (rq_left > 0) rq_left--;
        else begin
          rd_req_ready = 1'b1;
          pend_off = int'(rd_req_addr - img_base);
          pend = 1;
          lat_left = lat_cfg;
          rq_left = req_stall_cfg;
          rd_count++;
        end
      end
      ps_ready = 1'b0;
      if (ps_valid) begin
        if (ps_left > 0) ps_left--;
        else begin
          ps_ready = 1'b1;
          if (ps_addr != 11'(wr_count) || ps_data != pay_byte(wr_count)) wr_bad++;
          wr_count++;
          ps_left = ps_stall_cfg;
        end
      end
    end
  end

  // Completion monitor.
  initial begin
    bit pd = 0, pi = 0;
    forever begin
      @(negedge clk);
      if (done) done_count++;
      if (init_start) init_count++;
      if (init_start != pd) init_bad++;
      if (pi && busy) busy_bad++;
      if (init_start && !busy) busy_bad++;
      pd = done;
      pi = init_start;
    end
  end

  task automatic clear_counts();
    rd_count = 0; rd_bad = 0; wr_count = 0; wr_bad = 0; proto_bad = 0;
    done_count = 0; init_count = 0; init_bad = 0; busy_bad = 0;
  endtask

  task automatic start(input logic [31:0] base, input logic [31:0] lid);
    clear_counts();
    img_base = base;
    local_id = lid;
    @(negedge clk);
    trig_we = 1'b1; trig_addr = base;
    @(negedge clk);
    trig_we = 1'b0; trig_addr = ~base;
    chk(busy == 1'b1, "R2 busy after trigger", 64'(busy), 64'd1);
    chk(id_err == 1'b0, "R8 err cleared by trigger", 64'(id_err), 64'd0);
  endtask

  task automatic run_good(input logic [31:0] base, input logic [31:0] id, input logic [31:0] dt,
                          input logic [31:0] cs, input int rs, input int lt, input int pss,
                          input bit mid_trig);
    img_id = id; img_date = dt; img_csum = cs;
    req_stall_cfg = rs; lat_cfg = lt; ps_stall_cfg = pss;
    start(base, id);
    if (mid_trig) begin
      repeat (300) @(negedge clk);
      trig_we = 1'b1; trig_addr = base ^ 32'h0000_0100;
      @(negedge clk);
      trig_we = 1'b0;
    end
    for (int t = 0; t < 40000 && init_count == 0; t++) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(rd_count == IMG && rd_bad == 0, "R2 read sequence", 64'(rd_count), 64'(IMG));
    chk(proto_bad == 0, "R3 read handshake", 64'(proto_bad), 64'd0);
    chk(hdr_date == dt && hdr_cpu_id == id, "R4 date/id capture",
        {hdr_date, hdr_cpu_id}, {dt, id});
    chk(hdr_csum == cs, "R4 checksum capture", 64'(hdr_csum), 64'(cs));
    chk(wr_count == PAY && wr_bad == 0, "R5 store writes", 64'(wr_count), 64'(PAY));
    chk(done_count == 1 && id_err == 1'b0, "R6 arbitrary checksum completes",
        64'(done_count), 64'd1);
    chk(init_count == 1 && init_bad == 0, "R9 done then init_start",
        64'(init_bad), 64'd0);
    chk(busy == 1'b0 && busy_bad == 0, "R9 busy release", 64'(busy_bad), 64'd0);
    if (mid_trig)
      chk(rd_bad == 0 && wr_count == PAY, "R10 busy trigger ignored", 64'(rd_bad), 64'd0);
  endtask

  task automatic run_bad(input int j);
    logic [31:0] id = 32'h0000_0630 + 32'(j);
    img_id = id; img_date = 32'h1111_0000 + 32'(j); img_csum = 32'h0;
    req_stall_cfg = 0; lat_cfg = 1; ps_stall_cfg = 1;
    start(32'h0002_0000 + 32'(j) * 32'h1000, id ^ (32'h1 << (8 * j)));
    for (int t = 0; t < 2000 && busy; t++) @(negedge clk);
    repeat (20) @(negedge clk);
    chk(id_err == 1'b1, "R7 id mismatch flagged", 64'(id_err), 64'd1);
    chk(rd_count == 8 && rd_bad == 0, "R7 reads stop after id", 64'(rd_count), 64'd8);
    chk(wr_count == 0 && done_count == 0 && init_count == 0 && !busy,
        "R7 no write/done/init", 64'(wr_count + done_count + init_count), 64'd0);
    chk(id_err == 1'b1, "R8 err held while idle", 64'(id_err), 64'd1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    img_base = '0; img_date = '0; img_id = '0; img_csum = '0;
    req_stall_cfg = 0; lat_cfg = 0; ps_stall_cfg = 0;
    clear_counts();
    repeat (3) @(negedge clk);
    chk(!busy && !done && !init_start && !id_err && !rd_req_valid && !rd_rsp_ready && !ps_valid,
        "R1 reset state", {57'd0, busy, done, init_start, id_err, rd_req_valid, rd_rsp_ready, ps_valid}, 64'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!busy && !rd_req_valid && !ps_valid, "R1 idle after reset",
        {61'd0, busy, rd_req_valid, ps_valid}, 64'd0);
    run_good(32'h0001_0000, 32'h0000_0652, 32'h2024_0915, 32'hDEAD_BEEF, 0, 0, 0, 0);
    run_good(32'h0004_2A37, 32'h0000_0633, 32'h1999_0101, 32'h0000_0000, 1, 2, 0, 0);
    run_good(32'h7FFF_F000, 32'hC001_D00D, 32'h0000_0001, 32'h1234_5678, 2, 0, 3, 0);
    for (int j = 0; j < 4; j++) run_bad(j);
    run_good(32'h0009_8001, 32'h0000_0651, 32'h2001_0203, 32'hFFFF_FFFF, 0, 1, 1, 1);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule